// File: doc/BRIEF.md
# Byte-Programmed PWM Generator

The block produces a single pulse-width-modulated output whose high time and low time are each a 16-bit count of microseconds. A prescaler divides the system clock down to a one-microsecond tick, and two counters run the high phase and the low phase from that tick. Software writes the counts one byte at a time. The bytes are held in a staging area and are committed together only when the most significant byte of the high time is written. A committed pair takes effect at the start of the next period, so a period that has already begun always finishes with the values it started with.

Two mode inputs select the behaviour. In repeating mode the waveform cycles until the enable is dropped. In single-pulse mode one high phase and one low phase are produced, and the output then stays low until the enable is dropped and raised again. A gating option ANDs the output with an external input. That input is used exactly as it arrives: any filtering applied before it, such as debounce, delays the gating by the same amount.

Top module: `pwm_byte_gen`

## Requirements
- R1: After reset `pwm_out` is low and both committed counts are zero.
- R2: A write with `wr_en` high stores `wr_data` in the byte chosen by `wr_sel`. Code 0 selects the low-time low byte, 1 the low-time high byte, 2 the high-time low byte and 3 the high-time high byte. Each count is 16 bits wide: {high byte, low byte}.
- R3: Writes with select codes 0, 1 or 2 leave the committed counts and the waveform unchanged. A write with code 3 commits all four bytes together on that clock edge.
- R4: One count unit lasts `CLK_PER_US` clock cycles. High and low counts of 1 give a two-unit period with a 50% duty cycle.
- R5: In repeating mode (`one_shot` = 0), the output goes high in the cycle after `run_en` is first sampled high. It stays high for the high count in units, then low for the low count in units, and repeats.
- R6: In single-pulse mode (`one_shot` = 1), exactly one high phase and one low phase are produced. The output then stays low while `run_en` remains high.
- R7: While `run_en` is low the output is low. Raising `run_en` again restarts the waveform from the beginning of a high phase.
- R8: A count committed during a period does not change that period. The new counts are loaded at the next period start.
- R9: A high count of zero holds the output low.
- R10: A low count of zero with a nonzero high count holds the output high.
- R11: With `gate_en` high, `pwm_out` is the AND of the internal waveform and `gate_in` in the same cycle. With `gate_en` low, `gate_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Byte select code (see R2) |
| wr_data | input | 8 | Byte to write |
| run_en | input | 1 | Generator enable |
| one_shot | input | 1 | 1 = single pulse, 0 = repeating |
| gate_en | input | 1 | Enable AND-gating with gate_in |
| gate_in | input | 1 | External gating signal |
| pwm_out | output | 1 | Generated waveform |

## Verification
The hardest case to reach is a commit that lands in the middle of a running period, because only then does the load-at-boundary rule differ from an immediate load. The stimulus first commits a long period and stages new low bytes without committing them. It then starts the generator and issues the single high-byte write part way through the first high phase. Counting the high cycles of the first and second periods separates an immediate load from a deferred one.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_DONE = 2'd3
    } pwm_phase_e;

    localparam logic [1:0] SEL_OFF_LO = 2'd0;
    localparam logic [1:0] SEL_OFF_HI = 2'd1;
    localparam logic [1:0] SEL_ON_LO  = 2'd2;
    localparam logic [1:0] SEL_ON_HI  = 2'd3;

endpackage

// File: rtl/pwm_us_tick.sv
module pwm_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr || st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign tick = !clr && (st_q.cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_gen_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cm_on,
    output logic [CNT_W-1:0]  cm_off
);
    typedef struct packed {
        logic [BYTE_W-1:0] stg_off_lo;
        logic [BYTE_W-1:0] stg_off_hi;
        logic [BYTE_W-1:0] stg_on_lo;
        logic [CNT_W-1:0]  on;
        logic [CNT_W-1:0]  off;
    } shd_st_t;

    shd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_OFF_LO: st_d.stg_off_lo = wr_data;
                SEL_OFF_HI: st_d.stg_off_hi = wr_data;
                SEL_ON_LO:  st_d.stg_on_lo  = wr_data;
                SEL_ON_HI: begin
                    st_d.on  = {wr_data, st_q.stg_on_lo};
                    st_d.off = {st_q.stg_off_hi, st_q.stg_off_lo};
                end
                default: ;
            endcase
        end
    end

    assign cm_on  = st_q.on;
    assign cm_off = st_q.off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_phase_core.sv
module pwm_phase_core
    import pwm_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             one_shot,
    input  logic             tick,
    input  logic [CNT_W-1:0] cm_on,
    input  logic [CNT_W-1:0] cm_off,
    output pwm_phase_e       phase,
    output logic [CNT_W-1:0] act_on,
    output logic [CNT_W-1:0] act_off,
    output logic             raw_out
);
    typedef struct packed {
        pwm_phase_e       ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] on;
        logic [CNT_W-1:0] off;
    } core_st_t;

    core_st_t st_d, st_q;

    // A phase of length zero still occupies one tick so that the period
    // boundary, and with it the reload of counts, keeps happening.
    function automatic logic last_unit(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] len);
        return (len == '0) || (c == len - 1'b1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (!run_en) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    st_d.ph  = PH_HIGH;
                    st_d.cnt = '0;
                    st_d.on  = cm_on;
                    st_d.off = cm_off;
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (last_unit(st_q.cnt, st_q.on)) begin
                            st_d.ph  = PH_LOW;
                            st_d.cnt = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (last_unit(st_q.cnt, st_q.off)) begin
                            st_d.cnt = '0;
                            if (one_shot) begin
                                st_d.ph = PH_DONE;
                            end else begin
                                st_d.ph  = PH_HIGH;
                                st_d.on  = cm_on;
                                st_d.off = cm_off;
                            end
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_DONE: st_d.cnt = '0;
                default: st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st_q.ph)
            PH_HIGH: raw_out = (st_q.on != '0);
            PH_LOW:  raw_out = (st_q.on != '0) && (st_q.off == '0);
            default: raw_out = 1'b0;
        endcase
    end

    assign phase   = st_q.ph;
    assign act_on  = st_q.on;
    assign act_off = st_q.off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, cnt: '0, on: '0, off: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_byte_gen.sv
module pwm_byte_gen
    import pwm_gen_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              run_en,
    input  logic              one_shot,
    input  logic              gate_en,
    input  logic              gate_in,
    output logic              pwm_out
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] cm_on, cm_off;
    logic [CNT_W-1:0] act_on, act_off;
    pwm_phase_e       core_phase;
    logic             us_tick;
    logic             raw_out;

    pwm_shadow_regs #(.BYTE_W(BYTE_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cm_on   (cm_on),
        .cm_off  (cm_off)
    );

    pwm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (core_phase == PH_IDLE),
        .tick  (us_tick)
    );

    pwm_phase_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .one_shot (one_shot),
        .tick     (us_tick),
        .cm_on    (cm_on),
        .cm_off   (cm_off),
        .phase    (core_phase),
        .act_on   (act_on),
        .act_off  (act_off),
        .raw_out  (raw_out)
    );

    assign pwm_out = raw_out & (gate_in | ~gate_en);
endmodule

module pwm_byte_gen_chk
    import pwm_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             run_en,
    input logic             gate_en,
    input logic             gate_in,
    input logic             pwm_out,
    input pwm_phase_e       core_phase,
    input logic [CNT_W-1:0] cm_on,
    input logic [CNT_W-1:0] cm_off,
    input logic [CNT_W-1:0] act_on,
    input logic [CNT_W-1:0] act_off
);
    a_r3_commit_only_on_hi: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && wr_sel == SEL_ON_HI) |-> ($stable(cm_on) && $stable(cm_off)));

    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_en) |-> !pwm_out);

    a_r6_done_low: assert property (@(posedge clk) disable iff (!rst_n)
        (core_phase == PH_DONE) |-> !pwm_out);

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (core_phase == PH_DONE && run_en) |=> (core_phase == PH_DONE));

    a_r8_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_on) || !$stable(act_off)) |-> ($past(core_phase) != PH_HIGH));

    a_r9_zero_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act_on == '0) |-> !pwm_out);

    a_r11_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !gate_in) |-> !pwm_out);
endmodule

bind pwm_byte_gen pwm_byte_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .run_en     (run_en),
    .gate_en    (gate_en),
    .gate_in    (gate_in),
    .pwm_out    (pwm_out),
    .core_phase (core_phase),
    .cm_on      (cm_on),
    .cm_off     (cm_off),
    .act_on     (act_on),
    .act_off    (act_off)
);

// File: tb/pwm_byte_gen_test.sv
module pwm_byte_gen_test;
    localparam int DIV = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       run_en = 1'b0;
    logic       one_shot = 1'b0;
    logic       gate_en = 1'b0;
    logic       gate_in = 1'b0;
    logic       pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwm_byte_gen #(.CLK_PER_US(DIV), .BYTE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .run_en(run_en), .one_shot(one_shot),
        .gate_en(gate_en), .gate_in(gate_in), .pwm_out(pwm_out)
    );

    // Vector fields: {on[15:0], off[15:0], shot, window[15:0], ones[15:0], first}
    localparam int NV = 8;
    localparam logic [65:0] VECS [NV] = '{
        {16'd1, 16'd1, 1'b0, 16'd200, 16'd100, 1'b1},  // R4 two-unit period
        {16'd3, 16'd1, 1'b0, 16'd400, 16'd300, 1'b1},  // R5
        {16'd2, 16'd5, 1'b0, 16'd700, 16'd200, 1'b1},  // R5
        {16'd2, 16'd3, 1'b1, 16'd500, 16'd100, 1'b1},  // R6
        {16'd0, 16'd4, 1'b0, 16'd400, 16'd0,   1'b0},  // R9
        {16'd3, 16'd0, 1'b0, 16'd300, 16'd300, 1'b1},  // R10
        {16'd0, 16'd0, 1'b0, 16'd200, 16'd0,   1'b0},  // R9 both zero
        {16'd1, 16'd2, 1'b1, 16'd300, 16'd50,  1'b1}   // R6
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_counts(input logic [15:0] on, input logic [15:0] off);
        wr_byte(2'd0, off[7:0]);
        wr_byte(2'd1, off[15:8]);
        wr_byte(2'd2, on[7:0]);
        wr_byte(2'd3, on[15:8]);
    endtask

    task automatic stop_gen();
        @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic measure(input int w, output int ones, output int first);
        ones = 0; first = 0;
        @(negedge clk);
        run_en = 1'b1;
        for (int i = 0; i < w; i++) begin
            @(posedge clk);
            @(negedge clk);
            ones += int'(pwm_out);
            if (i == 0) first = int'(pwm_out);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        int ones, first, w;
        repeat (3) @(negedge clk);
        // R1: reset state; committed counts zero show as a low output once enabled
        check("R1 out in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        measure(200, ones, first);
        check("R1 zero counts after reset", ones, 0);
        stop_gen();

        // R7: disabled generator with valid counts stays low
        program_counts(16'd2, 16'd2);
        w = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            w += int'(pwm_out);
        end
        check("R7 low while disabled", w, 0);

        // Vector table: R2 R4 R5 R6 R9 R10, each run also restarts (R7)
        for (int v = 0; v < NV; v++) begin
            stop_gen();
            one_shot = VECS[v][33];
            program_counts(VECS[v][65:50], VECS[v][49:34]);
            measure(int'(VECS[v][32:17]), ones, first);
            check($sformatf("R5 vec%0d high cycles", v), ones, int'(VECS[v][16:1]));
            check($sformatf("R7 vec%0d starts high", v), first, int'(VECS[v][0]));
        end
        stop_gen();
        one_shot = 1'b0;

        // R2: 16-bit counts use the high byte (on = 0x0100 -> stays high long)
        program_counts(16'h0100, 16'd1);
        measure(300, ones, first);
        check("R2 high byte of on count", ones, 300);
        stop_gen();

        // R3 R8: commit 4/4, stage lows of 1/1, commit mid high phase
        program_counts(16'd4, 16'd4);
        wr_byte(2'd0, 8'd1);
        wr_byte(2'd2, 8'd1);
        measure(150, ones, first);
        check("R3 staged bytes not applied", ones, 150);
        stop_gen();
        ones = 0; w = 0;
        @(negedge clk);
        run_en = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i < 400) ones += int'(pwm_out);
            else         w    += int'(pwm_out);
            if (i == 99)  begin wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'd0; end
            if (i == 100) wr_en = 1'b0;
        end
        check("R8 current period unchanged", ones, 200);
        check("R3 commit applied next period", w, 100);
        stop_gen();

        // R11: gating with external input
        program_counts(16'd3, 16'd0);
        @(negedge clk);
        run_en = 1'b1;
        gate_en = 1'b1;
        repeat (5) @(negedge clk);
        gate_in = 1'b0;
        #1 check("R11 gate low blocks", int'(pwm_out), 0);
        gate_in = 1'b1;
        #1 check("R11 gate high passes", int'(pwm_out), 1);
        @(negedge clk);
        gate_in = 1'b0;
        #1 check("R11 gate same cycle", int'(pwm_out), 0);
        gate_en = 1'b0;
        #1 check("R11 gate_in ignored when off", int'(pwm_out), 1);
        stop_gen();

        summary();
    end
endmodule